// File: doc/BRIEF.md
# I2C Clock-Output Enable Controller

This block is a two-wire serial slave that keeps a bank of three byte-wide control registers. Each implemented bit enables or stops one of thirteen buffered clock outputs. The block exposes those bits as a plain enable vector. It samples the serial clock and data lines with a fast system clock. It recognises start and stop conditions, matches a fixed 7-bit device address, and acknowledges by pulling the data line low through an open-drain enable output.

A write frame carries two bytes after the address byte: a command byte and a count byte. The block acknowledges both and ignores their contents. Every later data byte lands in register 0, then register 1, and so on until a stop arrives. A read frame has no such bytes. The block streams register 0, register 1 and onward right after it acknowledges the address. There is no register pointer, so every transfer starts at register 0. After power-up all outputs run, and the serial interface is never required.

The block has no data stream at its edges and therefore no valid/ready handshake. The serial protocol carries its own flow control through the acknowledge bit. A controller that wants to stop a read sends a not-acknowledge.

Top module: `clk_en_i2c_ctrl`

## Requirements
- R1: After reset all 13 enable outputs are 1, the reserved register bits are 0, and `sda_oe` is 0 (the line is released).
- R2: A start is sampled SDA falling while SCL is high, and a stop is sampled SDA rising while SCL is high. Either condition ends any transfer in progress and releases SDA.
- R3: An address byte of 1101001 followed by a direction bit is acknowledged. Any other address gets no acknowledge, and the block ignores the bus until the next start.
- R4: In a write, the first two bytes after the address are acknowledged, and their values change no register.
- R5: Later write data bytes go to register 0, 1, 2 in that order, and each one is acknowledged. A register changes only when all 8 bits of its byte have arrived.
- R6: The enables map as follows. Register 0 bit 7 drives output 5, bit 6 drives output 4, and bits 3..0 drive outputs 3..0. Register 1 bits 5..0 drive outputs 11..6. Register 2 bit 0 drives output 12. A 1 means the output is active.
- R7: Reserved bits ignore writes and read back as 0. These are bits 5..4 of register 0, bits 7..6 of register 1 and bits 7..1 of register 2.
- R8: Write data bytes past register 2 are acknowledged and discarded.
- R9: A read (direction bit 1) returns register 0, 1, 2 in turn, MSB first, and 0xFF for every byte past the end. The slave changes SDA only while SCL is low.
- R10: A not-acknowledge from the controller after a read byte ends the read, and the slave keeps SDA released.
- R11: A stop or repeated start in the middle of a byte discards that partial byte and keeps every register already fully written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low power-up reset |
| scl_i | input | 1 | Serial clock line as seen at the pin |
| sda_i | input | 1 | Serial data line as seen at the pin (wired-AND of all drivers) |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| clk_en | output | 13 | Per-output clock enable, 1 = running |

## Verification
The assertions assume the system clock samples SCL fast enough that each SCL phase lasts several cycles. They also assume the controller moves SDA only while SCL is low, apart from start and stop, so every edge the synchroniser sees is a true bus event. The bench's controller model holds each SCL phase for twelve system cycles and waits two cycles after SCL falls before it moves SDA. It drives SDA through the same wired-AND the pin would apply, so the lines never change together in one sample.

// File: rtl/clk_en_i2c_pkg.sv
package clk_en_i2c_pkg;
  localparam int NUM_OUT = 13;
  localparam int NUM_REG = 3;
  localparam int IDX_W   = 8;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RX,
    S_ACK,
    S_TX,
    S_MACK
  } eng_state_t;

  // Implemented bits of each register; a reserved bit is 0 in its mask.
  function automatic logic [7:0] reg_mask(input int idx);
    case (idx)
      0:       reg_mask = 8'hCF;
      1:       reg_mask = 8'h3F;
      2:       reg_mask = 8'h01;
      default: reg_mask = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/clk_en_line_sync.sv
module clk_en_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_ff[STAGES-1];
      sda_q  <= sda_ff[STAGES-1];
    end
  end

  assign scl_s     = scl_ff[STAGES-1];
  assign sda_s     = sda_ff[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/clk_en_regbank.sv
module clk_en_regbank
  import clk_en_i2c_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_addr,
  input  logic [7:0]         wr_data,
  input  logic [IDX_W-1:0]   rd_addr,
  output logic [7:0]         rd_data,
  output logic [NUM_OUT-1:0] en_vec
);
  logic [7:0] regs [NUM_REG];
  logic [NUM_REG*8-1:0] flat;

  for (genvar g = 0; g < NUM_REG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        regs[g] <= reg_mask(g);
      else if (wr_en && wr_addr == IDX_W'(g))
        regs[g] <= wr_data & reg_mask(g);
    end
    assign flat[g*8 +: 8] = regs[g];
  end

  always_comb begin
    rd_data = 8'hFF;
    for (int i = 0; i < NUM_REG; i++)
      if (rd_addr == IDX_W'(i)) rd_data = regs[i];
  end

  assign en_vec = {flat[16], flat[13:8], flat[7:6], flat[3:0]};

  a_r7_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(flat));
  a_r8_past_end_discard: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr >= IDX_W'(NUM_REG)) |=> $stable(flat));
endmodule

// File: rtl/clk_en_i2c_engine.sv
module clk_en_i2c_engine
  import clk_en_i2c_pkg::*;
#(
  parameter logic [6:0] SLV_ADDR = 7'h69
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_s,
  input  logic             sda_s,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_det,
  input  logic             stop_det,
  output logic             sda_oe,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_addr,
  output logic [7:0]       wr_data,
  output logic [IDX_W-1:0] rd_addr,
  input  logic [7:0]       rd_data
);
  eng_state_t       st;
  logic [3:0]       bitcnt;
  logic [7:0]       sh;
  logic             addr_ph, rw;
  logic [IDX_W-1:0] idx;
  logic             byte_in;

  assign byte_in = (st == S_RX) && scl_fall && (bitcnt == 4'd8) && !start_det && !stop_det;
  assign wr_en   = byte_in && !addr_ph && (idx >= IDX_W'(2));
  assign wr_addr = idx - IDX_W'(2);
  assign wr_data = sh;
  assign rd_addr = idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; bitcnt <= '0; sh <= '0; addr_ph <= 1'b0;
      rw <= 1'b0; idx <= '0; sda_oe <= 1'b0;
    end else if (start_det) begin
      st <= S_RX; bitcnt <= '0; addr_ph <= 1'b1; rw <= 1'b0;
      idx <= '0; sda_oe <= 1'b0;
    end else if (stop_det) begin
      st <= S_IDLE; sda_oe <= 1'b0;
    end else begin
      case (st)
        S_RX: begin
          if (scl_rise && bitcnt != 4'd8) begin
            sh     <= {sh[6:0], sda_s};
            bitcnt <= bitcnt + 4'd1;
          end else if (byte_in) begin
            if (addr_ph) begin
              addr_ph <= 1'b0;
              if (sh[7:1] == SLV_ADDR) begin
                rw <= sh[0]; st <= S_ACK; sda_oe <= 1'b1;
              end else begin
                st <= S_IDLE;
              end
            end else begin
              if (idx != '1) idx <= idx + IDX_W'(1);
              st <= S_ACK; sda_oe <= 1'b1;
            end
          end
        end
        S_ACK: if (scl_fall) begin
          bitcnt <= '0;
          if (rw) begin
            sh <= rd_data; sda_oe <= ~rd_data[7]; st <= S_TX;
          end else begin
            sda_oe <= 1'b0; st <= S_RX;
          end
        end
        S_TX: if (scl_fall) begin
          if (bitcnt == 4'd7) begin
            sda_oe <= 1'b0; st <= S_MACK;
            if (idx != '1) idx <= idx + IDX_W'(1);
          end else begin
            sh <= {sh[6:0], 1'b0}; sda_oe <= ~sh[6]; bitcnt <= bitcnt + 4'd1;
          end
        end
        S_MACK: begin
          if (scl_rise && sda_s) st <= S_IDLE;
          else if (scl_fall) begin
            sh <= rd_data; sda_oe <= ~rd_data[7]; bitcnt <= '0; st <= S_TX;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r2_release_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);
  a_r3_no_ack_on_mismatch: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_in && addr_ph && sh[7:1] != SLV_ADDR) |=> !sda_oe);
  a_r9_drive_only_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);
  a_r9_hold_while_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_TX && scl_s && !start_det && !stop_det) |=> $stable(sda_oe));
  a_r10_release_after_nack: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_MACK && scl_rise && sda_s) |=> !sda_oe);
endmodule

// File: rtl/clk_en_i2c_ctrl.sv
module clk_en_i2c_ctrl
  import clk_en_i2c_pkg::*;
#(
  parameter logic [6:0] SLV_ADDR    = 7'h69,
  parameter int         SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe,
  output logic [NUM_OUT-1:0] clk_en
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic wr_en;
  logic [IDX_W-1:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;

  clk_en_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  clk_en_i2c_engine #(.SLV_ADDR(SLV_ADDR)) u_engine (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .sda_oe(sda_oe),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  clk_en_regbank u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .en_vec(clk_en)
  );

  a_r5_enables_move_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(clk_en));
endmodule

// File: tb/clk_en_i2c_ctrl_bench.sv
module clk_en_i2c_ctrl_bench;
  localparam int H = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe;
  logic [12:0] clk_en;
  wire  sda_line = sda_m & ~sda_oe;

  int checks = 0, errors = 0;
  bit done = 1'b0, cmp_on = 1'b0;
  int mism = 0;
  logic [7:0] mreg [3];

  always #4 clk = ~clk;

  clk_en_i2c_ctrl u_clk_en_i2c_ctrl (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .clk_en(clk_en)
  );

  function automatic logic [7:0] mmask(input int i);
    if (i == 0) return 8'b1100_1111;
    if (i == 1) return 8'b0011_1111;
    if (i == 2) return 8'b0000_0001;
    return 8'h00;
  endfunction

  function automatic logic [12:0] exp_en();
    logic [12:0] e;
    e[0] = mreg[0][0]; e[1] = mreg[0][1]; e[2] = mreg[0][2]; e[3] = mreg[0][3];
    e[4] = mreg[0][6]; e[5] = mreg[0][7];
    for (int k = 0; k < 6; k++) e[6+k] = mreg[1][k];
    e[12] = mreg[2][0];
    return e;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Per-clock comparison against the model (R6); a short settle window is allowed.
  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      checks++;
      if (clk_en !== exp_en()) begin
        mism++;
        if (mism == 6) begin
          errors++;
          $display("FAIL R6 clock compare actual=%0h expected=%0h", clk_en, exp_en());
        end
      end else mism = 0;
    end
  end

  task automatic w(input int n); repeat (n) @(negedge clk); endtask

  task automatic bus_start();
    sda_m = 1; w(H); scl_m = 1; w(H); sda_m = 0; w(H); scl_m = 0; w(2);
  endtask

  task automatic bus_stop();
    sda_m = 0; w(H); scl_m = 1; w(H); sda_m = 1; w(H);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; w(H); scl_m = 1; w(H); scl_m = 0; w(2);
  endtask

  task automatic send_bits(input logic [7:0] v, input int n);
    for (int i = 7; i > 7 - n; i--) send_bit(v[i]);
  endtask

  // Send a byte; if tgt >= 0 it is write data for that register index.
  task automatic send_byte(input logic [7:0] v, input int tgt, output logic ack);
    send_bits(v, 8);
    if (tgt >= 0 && tgt < 3) mreg[tgt] = v & mmask(tgt);
    sda_m = 1; w(H); scl_m = 1; w(H/2); ack = sda_line; w(H - H/2); scl_m = 0; w(2);
  endtask

  task automatic recv_byte(input logic nack, output logic [7:0] v);
    v = '0;
    for (int i = 0; i < 8; i++) begin
      sda_m = 1; w(H); scl_m = 1; w(H/2); v = {v[6:0], sda_line}; w(H - H/2);
      scl_m = 0; w(2);
    end
    send_bit(nack);
  endtask

  logic a;
  logic [7:0] rb;

  initial begin
    for (int i = 0; i < 3; i++) mreg[i] = mmask(i);
    w(5); rst_n = 1; w(3);
    chk(clk_en == 13'h1FFF, "R1 enables after reset", clk_en, 13'h1FFF);
    chk(sda_oe == 1'b0, "R1 sda released after reset", sda_oe, 0);
    cmp_on = 1;

    // Write three registers
    bus_start();
    send_byte(8'hD2, -1, a); chk(a == 0, "R3 address ack", a, 0);
    send_byte(8'h5A, -1, a); chk(a == 0, "R4 command ack", a, 0);
    chk(clk_en == 13'h1FFF, "R4 command byte changes nothing", clk_en, 13'h1FFF);
    send_byte(8'h00, -1, a); chk(a == 0, "R4 count ack", a, 0);
    chk(clk_en == 13'h1FFF, "R4 count byte changes nothing", clk_en, 13'h1FFF);
    send_byte(8'h35, 0, a); chk(a == 0, "R5 reg0 ack", a, 0);
    send_byte(8'hAA, 1, a); chk(a == 0, "R5 reg1 ack", a, 0);
    send_byte(8'hFE, 2, a); chk(a == 0, "R5 reg2 ack", a, 0);
    bus_stop();
    chk(clk_en == 13'h0A85, "R6 enable mapping", clk_en, 13'h0A85);

    // Read back including past end
    bus_start();
    send_byte(8'hD3, -1, a); chk(a == 0, "R9 read address ack", a, 0);
    recv_byte(0, rb); chk(rb == 8'h05, "R7 reg0 reserved read 0", rb, 8'h05);
    recv_byte(0, rb); chk(rb == 8'h2A, "R9 reg1 read", rb, 8'h2A);
    recv_byte(0, rb); chk(rb == 8'h00, "R9 reg2 read", rb, 8'h00);
    recv_byte(1, rb); chk(rb == 8'hFF, "R9 past end reads FF", rb, 8'hFF);
    w(4); chk(sda_oe == 0, "R10 released after nack", sda_oe, 0);
    bus_stop();

    // Wrong address
    bus_start();
    send_byte(8'hA4, -1, a); chk(a == 1, "R3 mismatch no ack", a, 1);
    send_byte(8'h00, -1, a); chk(a == 1, "R3 ignored after mismatch", a, 1);
    send_byte(8'h00, -1, a); chk(a == 1, "R3 still ignored", a, 1);
    send_byte(8'h00, -1, a);
    bus_stop();
    chk(clk_en == exp_en(), "R3 regs unchanged", clk_en, exp_en());

    // Command and count only
    bus_start();
    send_byte(8'hD2, -1, a); send_byte(8'h00, -1, a); send_byte(8'h00, -1, a);
    bus_stop();
    chk(clk_en == 13'h0A85, "R4 dummies only keep regs", clk_en, 13'h0A85);

    // Past end writes
    bus_start();
    send_byte(8'hD2, -1, a); send_byte(8'h11, -1, a); send_byte(8'h22, -1, a);
    send_byte(8'hFF, 0, a); send_byte(8'hFF, 1, a); send_byte(8'hFF, 2, a);
    send_byte(8'h00, -1, a); chk(a == 0, "R8 past end write acked", a, 0);
    send_byte(8'h12, -1, a); chk(a == 0, "R8 second past end acked", a, 0);
    bus_stop();
    chk(clk_en == 13'h1FFF, "R8 past end discarded", clk_en, 13'h1FFF);

    // Abort by stop mid-byte
    bus_start();
    send_byte(8'hD2, -1, a); send_byte(8'h00, -1, a); send_byte(8'h00, -1, a);
    send_byte(8'h00, 0, a);
    send_bits(8'h00, 4);
    bus_stop();
    chk(clk_en == 13'h1FC0, "R11 partial byte discarded on stop", clk_en, 13'h1FC0);

    // Abort by repeated start mid-byte, then read
    bus_start();
    send_byte(8'hD2, -1, a); send_byte(8'h00, -1, a); send_byte(8'h00, -1, a);
    send_bits(8'h00, 3);
    bus_start();
    send_byte(8'hD3, -1, a); chk(a == 0, "R2 repeated start address ack", a, 0);
    recv_byte(0, rb); chk(rb == 8'h00, "R11 reg0 kept", rb, 8'h00);
    recv_byte(1, rb); chk(rb == 8'h3F, "R11 reg1 untouched", rb, 8'h3F);
    w(4); chk(sda_oe == 0, "R10 nack releases line", sda_oe, 0);
    bus_stop();

    // Single-byte read ended by nack, then a fresh write works
    bus_start();
    send_byte(8'hD3, -1, a); recv_byte(1, rb);
    chk(rb == 8'h00, "R9 first byte is reg0", rb, 8'h00);
    bus_stop();
    chk(sda_oe == 0, "R2 released after stop", sda_oe, 0);
    bus_start();
    send_byte(8'hD2, -1, a); send_byte(8'h00, -1, a); send_byte(8'h00, -1, a);
    send_byte(8'hC3, 0, a); chk(a == 0, "R5 new write acked", a, 0);
    bus_stop();
    chk(clk_en == 13'h1FF3, "R6 final mapping", clk_en, 13'h1FF3);

    w(10);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule